// File: doc/BRIEF.md
# Two-Dimensional Pattern Fill Engine

The block writes a computed pattern into a memory that takes one write per clock. A single-cycle start request launches a run. The block then walks a row index and a column index, with the column index as the inner one. Each of these cycles it drives one write of the pattern word for the current index pair to an address that begins at a base value and rises by one per write. A one-cycle setup step comes before the write loop and a one-cycle wrap-up step comes after it. When the run is over, the block sits idle with its finished flag raised until the next start request.

The row count, column count, base address, address width, data width and pattern choice are all parameters. Pattern 0 places the row index shifted left by eight bits and XORs the column index into the low bits. Pattern 1 gives the linear position row*COLS + column. The memory itself sits outside the block, and the block has no read path.

Top module: `pattern_fill`

## Requirements
- R1: While reset is asserted and right after it, the block is idle: done_o = 1 and wr_en_o = 0.
- R2: A start_i pulse sampled while done_o = 1 makes done_o drop at the next edge. The first cycle after that is a setup cycle with no write, and writes begin in the cycle after it.
- R3: The first write of a run goes to BASE_ADDR. Each later write of the run goes to the previous write address plus one, with writes on consecutive cycles.
- R4: Writes follow row-major order: the column index runs from 0 to COLS-1 for each row index from 0 to ROWS-1.
- R5: With PATTERN = 0, the write data equals (row << 8) XOR column, with the row index in bits 8 and up and the column index in the low bits.
- R6: Each run issues exactly ROWS*COLS writes.
- R7: After the last write there is one wrap-up cycle with no write and done_o = 0. done_o then rises, so done_o is low for ROWS*COLS+2 cycles per run.
- R8: A start_i pulse while a run is in progress (done_o = 0) is ignored: the write sequence and run length stay unchanged.
- R9: Without start_i, an idle block keeps done_o = 1 and issues no writes.
- R10: A new start after a finished run repeats an identical run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run request, honoured only while idle |
| done_o | output | 1 | High while idle or finished |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | ADDR_W | Memory write address |
| wr_data_o | output | DATA_W | Memory write data (pattern word) |

## Verification
The assertions assume the following about the inputs:
- start_i is synchronous to clk and never unknown after reset.
- BASE_ADDR + ROWS*COLS fits in ADDR_W bits, so the address step check never meets a wrap.

The stimulus drives start_i only on falling edges, as single-cycle pulses, so every request is sampled by exactly one rising edge. It uses the default geometry, which stays well inside the address range. One of those pulses is placed in the middle of a run to test that it is ignored.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_WALK  = 2'd1,
    PH_WRAP  = 2'd2,
    PH_IDLE  = 2'd3
  } fill_phase_e;
endpackage

// File: rtl/fill_sequencer.sv
module fill_sequencer
  import fill_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        last_i,
  output fill_phase_e phase_o
);
  fill_phase_e phase_q, phase_d;

  // next-state
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start_i) phase_d = PH_SETUP;
      PH_SETUP: phase_d = PH_WALK;
      PH_WALK:  if (last_i) phase_d = PH_WRAP;
      PH_WRAP:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/fill_index.sv
module fill_index
  import fill_pkg::*;
#(
  parameter int unsigned ROWS      = 4,
  parameter int unsigned COLS      = 5,
  parameter int unsigned I_W       = 2,
  parameter int unsigned J_W       = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fill_phase_e       phase_i,
  output logic [I_W-1:0]    row_o,
  output logic [J_W-1:0]    col_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [I_W-1:0]    ROW_LAST = I_W'(ROWS - 1);
  localparam logic [J_W-1:0]    COL_LAST = J_W'(COLS - 1);
  localparam logic [ADDR_W-1:0] ADDR_INIT = ADDR_W'(BASE_ADDR);

  logic [I_W-1:0]    row_q, row_d;
  logic [J_W-1:0]    col_q, col_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              load_en, step_en, upd_en;

  assign load_en = (phase_i == PH_SETUP);
  assign step_en = (phase_i == PH_WALK);
  assign upd_en  = load_en | step_en;

  // next-state for the index pair and address
  always_comb begin
    row_d  = row_q;
    col_d  = col_q;
    addr_d = addr_q;
    if (load_en) begin
      row_d  = '0;
      col_d  = '0;
      addr_d = ADDR_INIT;
    end else if (step_en) begin
      addr_d = addr_q + ADDR_W'(1);
      if (col_q != COL_LAST) begin
        col_d = col_q + J_W'(1);
      end else begin
        col_d = '0;
        if (row_q != ROW_LAST) row_d = row_q + I_W'(1);
      end
    end
  end

  // registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      addr_q <= '0;
    end else if (upd_en) begin
      row_q  <= row_d;
      col_q  <= col_d;
      addr_q <= addr_d;
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign addr_o = addr_q;
  assign last_o = (row_q == ROW_LAST) && (col_q == COL_LAST);
endmodule

// File: rtl/fill_pattern.sv
module fill_pattern #(
  parameter int unsigned I_W     = 2,
  parameter int unsigned J_W     = 3,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned COLS    = 5,
  parameter int unsigned PATTERN = 0
) (
  input  logic [I_W-1:0]    row_i,
  input  logic [J_W-1:0]    col_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] row_w, col_w;
  assign row_w = DATA_W'(row_i);
  assign col_w = DATA_W'(col_i);

  generate
    if (PATTERN == 0) begin : g_shift_xor
      assign data_o = (row_w << 8) ^ col_w;
    end else begin : g_linear
      assign data_o = row_w * DATA_W'(COLS) + col_w;
    end
  endgenerate
endmodule

// File: rtl/pattern_fill.sv
module pattern_fill
  import fill_pkg::*;
#(
  parameter int unsigned ROWS      = 4,
  parameter int unsigned COLS      = 5,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BASE_ADDR = 32,
  parameter int unsigned PATTERN   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              done_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned I_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned J_W = (COLS > 1) ? $clog2(COLS) : 1;

  fill_phase_e       phase;
  logic              last;
  logic [I_W-1:0]    row;
  logic [J_W-1:0]    col;

  fill_sequencer u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .last_i  (last),
    .phase_o (phase)
  );

  fill_index #(
    .ROWS(ROWS), .COLS(COLS), .I_W(I_W), .J_W(J_W),
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase),
    .row_o   (row),
    .col_o   (col),
    .addr_o  (wr_addr_o),
    .last_o  (last)
  );

  fill_pattern #(
    .I_W(I_W), .J_W(J_W), .DATA_W(DATA_W), .COLS(COLS), .PATTERN(PATTERN)
  ) u_pat (
    .row_i  (row),
    .col_i  (col),
    .data_o (wr_data_o)
  );

  assign done_o  = (phase == PH_IDLE);
  assign wr_en_o = (phase == PH_WALK);
endmodule

// File: rtl/pattern_fill_chk.sv
module pattern_fill_chk #(
  parameter int unsigned ROWS      = 4,
  parameter int unsigned COLS      = 5,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              done_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o
);
  localparam logic [31:0] TOTAL = 32'(ROWS * COLS);
  logic [31:0] wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wr_cnt <= '0;
    else if (done_o && start_i)  wr_cnt <= '0;
    else if (wr_en_o)            wr_cnt <= wr_cnt + 32'd1;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && !wr_en_o)); // R9

  AST_START_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> !done_o); // R2

  AST_FIRST_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en_o) |-> (wr_addr_o == ADDR_W'(BASE_ADDR))); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + ADDR_W'(1))); // R3

  AST_WRITE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en_o) |-> (wr_cnt == TOTAL)); // R6

  AST_WRAP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en_o) |-> !done_o); // R7
endmodule

bind pattern_fill pattern_fill_chk #(
  .ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .done_o    (done_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o)
);

// File: tb/test_pattern_fill.sv
module test_pattern_fill;
  localparam int ROWS = 4;
  localparam int COLS = 5;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int BASE = 32;
  localparam int TOTAL = ROWS * COLS;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic done_o, wr_en_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [DATA_W-1:0] wr_data_o;

  wr_item_t exp_q[$];
  int n_checks = 0;
  int n_fails = 0;
  int run_writes = 0;
  int idle_writes = 0;

  always #2 clk = ~clk;

  pattern_fill #(
    .ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BASE_ADDR(BASE), .PATTERN(0)
  ) i_pattern_fill (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  // monitor: pops expected writes and compares them
  always @(negedge clk) begin
    if (rst_n && wr_en_o) begin
      run_writes++;
      if (exp_q.size() == 0) begin
        idle_writes++;
        check(1'b0, "R6 unexpected write", int'(wr_addr_o), -1);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        check(wr_addr_o == e.addr, "R3 address", int'(wr_addr_o), int'(e.addr));
        check(wr_data_o == e.data, "R4/R5 data", int'(wr_data_o), int'(e.data));
      end
    end
  end

  // driver: queues expected writes, launches a run and times it
  task automatic run_fill(input bit poke_mid, input string tag);
    int low_cnt;
    int first_idx;
    int last_idx;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        wr_item_t it;
        it.addr = ADDR_W'(BASE + r * COLS + c);
        it.data = (DATA_W'(r) << 8) ^ DATA_W'(c);
        exp_q.push_back(it);
      end
    end
    @(negedge clk);
    run_writes = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0, {"R2 done drop ", tag}, int'(done_o), 0);
    low_cnt = 0; first_idx = 0; last_idx = 0;
    while (!done_o && low_cnt < 1000) begin
      low_cnt++;
      if (wr_en_o) begin
        if (first_idx == 0) first_idx = low_cnt;
        last_idx = low_cnt;
      end
      if (poke_mid && low_cnt == 6) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    check(first_idx == 2, {"R2 first write slot ", tag}, first_idx, 2);
    check(last_idx == TOTAL + 1, {"R7 last write slot ", tag}, last_idx, TOTAL + 1);
    check(low_cnt == TOTAL + 2, {"R7 busy length ", tag}, low_cnt, TOTAL + 2);
    check(run_writes == TOTAL, {"R6 write count ", tag}, run_writes, TOTAL);
    check(exp_q.size() == 0, {"R4 queue drained ", tag}, exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(done_o == 1'b1, "R1 done in reset", int'(done_o), 1);
    check(wr_en_o == 1'b0, "R1 no write in reset", int'(wr_en_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o == 1'b1, "R1 done after reset", int'(done_o), 1);

    // R9: idle without start
    repeat (6) @(negedge clk);
    check(done_o == 1'b1, "R9 idle holds done", int'(done_o), 1);
    check(idle_writes == 0, "R9 no idle writes", idle_writes, 0);

    run_fill(1'b0, "run1");
    run_fill(1'b1, "R8 mid-run start");
    run_fill(1'b0, "R10 restart");

    repeat (5) @(negedge clk);
    check(done_o == 1'b1, "R9 idle after runs", int'(done_o), 1);
    check(idle_writes == 0, "R9 no stray writes", idle_writes, 0);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end
endmodule